// File: doc/BRIEF.md
# Peripheral I/O Window and Interrupt Configuration

This block holds the two configuration registers of a multi-function I/O controller that sets where a parallel port and two UARTs appear in the 10-bit ISA I/O space. Software reaches the registers through an index port and a data port. A window register picks one address window for each function. A power/test register holds the parallel-port interrupt choice, the UART test-mode bits, the parallel-port mode and a sticky write lock.

On every bus cycle the block compares the incoming I/O address with the configured windows. It raises at most one chip select, for the parallel port, UART1 or UART2. It also reports the interrupt number routed to each function. While a UART is in test mode and its line-control bit 7 is high, its serial output carries the baud clock.

Top module: `pio_cfg_decode`

## Requirements
- R1: A write to I/O address 398h loads the index. A write to 399h loads the register that the index selects: index 0 is the window register and index 1 is the power/test register. A read of 399h returns that register's value, and returns 00h for any other index. A read of 398h returns the index. `io_rdata` is 00h when no read of either port is in progress.
- R2: After reset the window register holds 10h. The power/test register holds 00h, except that bit 7 is the inverse of `strap_mode`.
- R3: Window bits 1:0 place the parallel port. 00 gives 378h–37Fh, 01 gives 3BCh–3BEh and 10 gives 278h–27Fh. Code 11 decodes no address.
- R4: Window bits 3:2 select the UART1 window and bits 5:4 select the UART2 window. Each window is 8 bytes long. Code 00 is at 3F8h and code 01 is at 2F8h. Code 10 is the third COM window and code 11 is the fourth. Window bits 7:6 set the base addresses of those two windows: 00 gives 3E8h/2E8h, 01 gives 338h/238h, 10 gives 2E8h/2E0h and 11 gives 220h/228h.
- R5: A UART on code 00 or 10 reports IRQ 4. A UART on code 01 or 11 reports IRQ 3.
- R6: With the parallel port at 378h, it reports IRQ 5 when power/test bit 3 is clear and IRQ 7 when that bit is set. At 3BCh or 278h it reports IRQ 7 and bit 3 has no effect. With the reserved code it reports 0.
- R7: Once power/test bit 6 is 1, writes to 399h change neither register. The bit stays 1 until reset.
- R8: When windows overlap, the parallel port wins over UART1 and UART1 wins over UART2. At most one chip select is high at any time.
- R9: When power/test bit 4 (UART1) or bit 5 (UART2) is 1 and that UART's LCR bit-7 input is 1, the UART's serial output carries its baud clock. Otherwise it carries its transmit data. `lpt_ext_mode` shows power/test bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| strap_mode | input | 1 | Strap pin; its inverse becomes power/test bit 7 at reset |
| io_addr | input | 10 | I/O address |
| io_wr | input | 1 | I/O write strobe, sampled on the clock edge |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the index and data ports |
| cs_lpt | output | 1 | Parallel-port chip select |
| cs_uart1 | output | 1 | UART1 chip select |
| cs_uart2 | output | 1 | UART2 chip select |
| lpt_irq | output | 4 | IRQ number of the parallel port (0 when the window is reserved) |
| uart1_irq | output | 4 | IRQ number of UART1 |
| uart2_irq | output | 4 | IRQ number of UART2 |
| lpt_ext_mode | output | 1 | Parallel-port extended mode |
| uart1_lcr7 | input | 1 | UART1 line-control bit 7 |
| uart2_lcr7 | input | 1 | UART2 line-control bit 7 |
| uart1_baud | input | 1 | UART1 baud clock |
| uart2_baud | input | 1 | UART2 baud clock |
| uart1_txd | input | 1 | UART1 transmit data |
| uart2_txd | input | 1 | UART2 transmit data |
| uart1_sout | output | 1 | UART1 serial output |
| uart2_sout | output | 1 | UART2 serial output |

## Verification
The assertions assume that `io_wr` and `io_rd` are never high in the same cycle. They also assume that a write strobe is held across a rising clock edge, so that each write takes effect exactly once. The bench keeps to these assumptions: it changes inputs only at the falling edge, and it lowers the strobes before it sweeps addresses.

The lock checks rely on `strap_mode` holding steady while the block is out of reset. The bench changes the strap only while reset is asserted.

// File: rtl/pio_cfg_decode.sv
module pio_cfg_decode #(
  parameter logic [9:0] IDX_PORT = 10'h398,
  parameter logic [9:0] DAT_PORT = 10'h399,
  parameter logic [7:0] WIN_RST  = 8'h10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_mode,
  input  logic [9:0] io_addr,
  input  logic       io_wr,
  input  logic       io_rd,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  output logic       cs_lpt,
  output logic       cs_uart1,
  output logic       cs_uart2,
  output logic [3:0] lpt_irq,
  output logic [3:0] uart1_irq,
  output logic [3:0] uart2_irq,
  output logic       lpt_ext_mode,
  input  logic       uart1_lcr7,
  input  logic       uart2_lcr7,
  input  logic       uart1_baud,
  input  logic       uart2_baud,
  input  logic       uart1_txd,
  input  logic       uart2_txd,
  output logic       uart1_sout,
  output logic       uart2_sout
);
  localparam logic [9:0] LPT_A = 10'h378;
  localparam logic [9:0] LPT_B = 10'h3BC;
  localparam logic [9:0] LPT_C = 10'h278;

  logic [7:0] idx_q, win_q, ptr_q;
  logic       locked;
  logic [9:0] base1, base2;
  logic       hit_lpt, hit1, hit2;

  assign locked = ptr_q[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= 8'h00;
      win_q <= WIN_RST;
      ptr_q <= {~strap_mode, 7'b0};
    end else if (io_wr) begin
      if (io_addr == IDX_PORT) idx_q <= io_wdata;
      else if (io_addr == DAT_PORT && !locked) begin
        if (idx_q == 8'd0) win_q <= io_wdata;
        else if (idx_q == 8'd1) ptr_q <= io_wdata;
      end
    end
  end

  always_comb begin
    io_rdata = 8'h00;
    if (io_rd && io_addr == IDX_PORT) io_rdata = idx_q;
    else if (io_rd && io_addr == DAT_PORT) begin
      if (idx_q == 8'd0) io_rdata = win_q;
      else if (idx_q == 8'd1) io_rdata = ptr_q;
    end
  end

  function automatic logic [9:0] com_base(input logic [1:0] code, input logic [1:0] pair);
    logic [9:0] b;
    case (code)
      2'd0: b = 10'h3F8;
      2'd1: b = 10'h2F8;
      2'd2: case (pair)
              2'd0: b = 10'h3E8;
              2'd1: b = 10'h338;
              2'd2: b = 10'h2E8;
              default: b = 10'h220;
            endcase
      default: case (pair)
              2'd0: b = 10'h2E8;
              2'd1: b = 10'h238;
              2'd2: b = 10'h2E0;
              default: b = 10'h228;
            endcase
    endcase
    return b;
  endfunction

  assign base1 = com_base(win_q[3:2], win_q[7:6]);
  assign base2 = com_base(win_q[5:4], win_q[7:6]);

  always_comb begin
    case (win_q[1:0])
      2'd0: hit_lpt = io_addr[9:3] == LPT_A[9:3];
      2'd1: hit_lpt = (io_addr[9:2] == LPT_B[9:2]) && (io_addr[1:0] != 2'b11);
      2'd2: hit_lpt = io_addr[9:3] == LPT_C[9:3];
      default: hit_lpt = 1'b0;
    endcase
  end

  assign hit1 = io_addr[9:3] == base1[9:3];
  assign hit2 = io_addr[9:3] == base2[9:3];

  assign cs_lpt   = hit_lpt;
  assign cs_uart1 = hit1 & ~hit_lpt;
  assign cs_uart2 = hit2 & ~hit1 & ~hit_lpt;

  always_comb begin
    case (win_q[1:0])
      2'd0: lpt_irq = ptr_q[3] ? 4'd7 : 4'd5;
      2'd1, 2'd2: lpt_irq = 4'd7;
      default: lpt_irq = 4'd0;
    endcase
  end

  assign uart1_irq = win_q[2] ? 4'd3 : 4'd4;
  assign uart2_irq = win_q[4] ? 4'd3 : 4'd4;

  assign lpt_ext_mode = ptr_q[7];
  assign uart1_sout = (ptr_q[4] & uart1_lcr7) ? uart1_baud : uart1_txd;
  assign uart2_sout = (ptr_q[5] & uart2_lcr7) ? uart2_baud : uart2_txd;
endmodule

module pio_cfg_decode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       strap_mode,
  input logic       io_wr,
  input logic [9:0] io_addr,
  input logic       cs_lpt,
  input logic       cs_uart1,
  input logic       cs_uart2,
  input logic [3:0] lpt_irq,
  input logic [3:0] uart1_irq,
  input logic [3:0] uart2_irq,
  input logic [7:0] win_q,
  input logic [7:0] ptr_q
);
  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q[6] |=> ptr_q[6]);
  p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q[6] |=> ($stable(win_q) && $stable(ptr_q)));
  p_one_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cs_lpt, cs_uart1, cs_uart2}));
  p_reserved_nodecode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q[1:0] == 2'b11) |-> !cs_lpt);
  p_lpt_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_lpt |-> (lpt_irq == 4'd5 || lpt_irq == 4'd7));
  p_uart_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (uart1_irq == 4'd3 || uart1_irq == 4'd4) && (uart2_irq == 4'd3 || uart2_irq == 4'd4));
  p_quiet_no_change_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> ($stable(win_q) && $stable(ptr_q)));
endmodule

bind pio_cfg_decode pio_cfg_decode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .strap_mode(strap_mode), .io_wr(io_wr), .io_addr(io_addr),
  .cs_lpt(cs_lpt), .cs_uart1(cs_uart1), .cs_uart2(cs_uart2),
  .lpt_irq(lpt_irq), .uart1_irq(uart1_irq), .uart2_irq(uart2_irq),
  .win_q(win_q), .ptr_q(ptr_q)
);

// File: tb/test_pio_cfg_decode.sv
module test_pio_cfg_decode;
  logic clk = 0, rst_n = 0, strap_mode = 0;
  logic [9:0] io_addr = 0;
  logic io_wr = 0, io_rd = 0;
  logic [7:0] io_wdata = 0, io_rdata;
  logic cs_lpt, cs_uart1, cs_uart2, lpt_ext_mode;
  logic [3:0] lpt_irq, uart1_irq, uart2_irq;
  logic uart1_lcr7 = 0, uart2_lcr7 = 0, uart1_baud = 0, uart2_baud = 0;
  logic uart1_txd = 0, uart2_txd = 0, uart1_sout, uart2_sout;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  pio_cfg_decode i_pio_cfg_decode (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic rd_reg(input int idx, output logic [7:0] v);
    wr(10'h398, 8'(idx));
    io_addr = 10'h399; io_rd = 1; #1 v = io_rdata; io_rd = 0;
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk); rst_n = 0; strap_mode = s;
    @(negedge clk); rst_n = 1;
  endtask

  function automatic logic [9:0] base_of(input int code, input int pair);
    if (code == 0) return 10'h3F8;
    if (code == 1) return 10'h2F8;
    if (code == 2) case (pair) 0: return 10'h3E8; 1: return 10'h338; 2: return 10'h2E8; default: return 10'h220; endcase
    case (pair) 0: return 10'h2E8; 1: return 10'h238; 2: return 10'h2E0; default: return 10'h228; endcase
  endfunction

  function automatic logic [2:0] exp_cs(input logic [7:0] w, input int a);
    logic l, u1, u2; int b1, b2;
    case (w[1:0])
      0: l = a >= 'h378 && a <= 'h37F;
      1: l = a >= 'h3BC && a <= 'h3BE;
      2: l = a >= 'h278 && a <= 'h27F;
      default: l = 0;
    endcase
    b1 = base_of(w[3:2], w[7:6]); b2 = base_of(w[5:4], w[7:6]);
    u1 = a >= b1 && a < b1 + 8 && !l;
    u2 = a >= b2 && a < b2 + 8 && !l && !(a >= b1 && a < b1 + 8);
    return {l, u1, u2};
  endfunction

  initial begin
    #(20 * 150000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int e;
    do_reset(1'b0);
    // R2 reset state
    rd_reg(0, v); chk(v == 8'h10, "R2 window reset", v, 8'h10);
    rd_reg(1, v); chk(v == 8'h80, "R2 ptr reset strap=0", v, 8'h80);
    chk(lpt_ext_mode == 1, "R9 ext mode", lpt_ext_mode, 1);
    do_reset(1'b1);
    rd_reg(1, v); chk(v == 8'h00, "R2 ptr reset strap=1", v, 8'h00);
    // R1 index read-back and unused index
    wr(10'h398, 8'h05);
    io_addr = 10'h398; io_rd = 1; #1 chk(io_rdata == 8'h05, "R1 index read", io_rdata, 5);
    io_addr = 10'h399; #1 chk(io_rdata == 8'h00, "R1 unused index", io_rdata, 0);
    io_rd = 0; #1 chk(io_rdata == 8'h00, "R1 idle rdata", io_rdata, 0);

    // R3 R4 R8 sweep of every window code and address; R5 R6 irq per code
    for (int p3 = 0; p3 < 2; p3++) begin
      wr(10'h398, 8'h01); wr(10'h399, 8'(p3 << 3));
      for (int w = 0; w < 256; w++) begin
        wr(10'h398, 8'h00); wr(10'h399, 8'(w));
        e = (w[3:2] == 0 || w[3:2] == 2) ? 4 : 3;
        chk(uart1_irq == 4'(e), "R5 uart1 irq", uart1_irq, e);
        e = (w[5:4] == 0 || w[5:4] == 2) ? 4 : 3;
        chk(uart2_irq == 4'(e), "R5 uart2 irq", uart2_irq, e);
        e = (w[1:0] == 3) ? 0 : (w[1:0] == 0 && p3 == 0) ? 5 : 7;
        chk(lpt_irq == 4'(e), "R6 lpt irq", lpt_irq, e);
        if (p3 == 0) begin
          for (int a = 0; a < 1024; a++) begin
            io_addr = 10'(a); #1;
            chk({cs_lpt, cs_uart1, cs_uart2} == exp_cs(8'(w), a), "R3 R4 R8 decode",
                {cs_lpt, cs_uart1, cs_uart2}, exp_cs(8'(w), a));
          end
        end
      end
    end

    // R9 test mode output selection
    wr(10'h398, 8'h01); wr(10'h399, 8'h10);
    uart1_lcr7 = 1; uart1_baud = 1; uart1_txd = 0; uart2_lcr7 = 1; uart2_baud = 1; uart2_txd = 0; #1;
    chk(uart1_sout == 1, "R9 uart1 baud out", uart1_sout, 1);
    chk(uart2_sout == 0, "R9 uart2 txd out", uart2_sout, 0);
    uart1_lcr7 = 0; #1 chk(uart1_sout == 0, "R9 uart1 lcr7 low", uart1_sout, 0);
    wr(10'h399, 8'h20); #1;
    chk(uart2_sout == 1, "R9 uart2 baud out", uart2_sout, 1);
    chk(lpt_ext_mode == 0, "R9 ext mode clear", lpt_ext_mode, 0);

    // R7 lock
    wr(10'h398, 8'h00); wr(10'h399, 8'h5A);
    wr(10'h398, 8'h01); wr(10'h399, 8'h40);
    wr(10'h399, 8'h00);
    rd_reg(1, v); chk(v == 8'h40, "R7 ptr locked", v, 8'h40);
    wr(10'h398, 8'h00); wr(10'h399, 8'hFF);
    rd_reg(0, v); chk(v == 8'h5A, "R7 window locked", v, 8'h5A);
    do_reset(1'b1);
    rd_reg(1, v); chk(v == 8'h00, "R7 reset clears lock", v, 0);
    wr(10'h398, 8'h00); wr(10'h399, 8'h33);
    rd_reg(0, v); chk(v == 8'h33, "R1 write after unlock", v, 8'h33);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule